// File: doc/BRIEF.md
# Bidirectional 80-bit Round Key Generator

This block holds the 80-bit key state of a 31-round substitution-permutation block cipher and produces the 64-bit round key for each round. A user key is loaded in one cycle. Each step strobe then moves the key state one round forward or one round back, depending on a direction pin. Forward steps pace encryption. Backward steps pace decryption and walk the schedule in reverse from the last round.

To begin decryption, the state after all 31 forward updates is needed. A fast-forward command produces that state without any help from outside. It runs the 31 forward updates on its own, one per cycle, and raises a done flag on the cycle the final state is registered. Backward steps can then be issued straight away.

The block carries no data stream. Every pin is a plain control or status signal with no back-pressure. Strobes are sampled on the rising clock edge. The round key and the round number are registered outputs and are valid in every cycle.

Top module: `rkey_sched80`

## Requirements
- R1: While reset is active, and after it is released, the key state is all zero, `round_o` is 1 and `ff_done_o` is 0.
- R2: `load_i` stores `key_i` in the key state, sets the round number to 1 and clears `ff_done_o`. It wins over `step_i` and `ff_start_i` in the same cycle.
- R3: `round_key_o` always equals bits [79:16] of the key state.
- R4: A forward step (`step_i`=1, `dir_i`=0) updates the state in three stages. First it rotates left by 61, giving new[79:0] = old[18:0] followed by old[79:19]. Next it replaces bits [79:76] with S(x), where S of the values 0 to F is C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2. Last it XORs the pre-step round number into bits [19:15].
- R5: A forward step increments the 5-bit round number modulo 32, so it reads 0 after 31 forward steps from a load.
- R6: A backward step (`step_i`=1, `dir_i`=1) decrements the round number first. It then XORs the new round number into bits [19:15], applies the inverse S-box (5,E,F,8,C,1,2,D,B,4,6,3,0,7,9,A for inputs 0 to F) to bits [79:76], and rotates right by 61.
- R7: 31 forward steps after a load, followed by 31 backward steps, give back the loaded key and round number 1.
- R8: With no load, step or fast-forward activity, the key state and the round number hold.
- R9: `ff_start_i` runs 31 forward steps on consecutive edges, starting at the edge that samples it. `ff_done_o` rises on the 31st of those edges, together with the final state.
- R10: During a fast-forward run, `step_i`, `dir_i` and `ff_start_i` have no effect. `ff_done_o` then stays high until the next load, step or `ff_start_i`.
- R11: A load during a fast-forward run stops the run. The loaded key stays in place and `ff_done_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe for `key_i` |
| key_i | input | 80 | User key |
| step_i | input | 1 | Single schedule step |
| dir_i | input | 1 | Step direction: 0 forward, 1 backward |
| ff_start_i | input | 1 | Start a 31-step fast-forward |
| ff_done_o | output | 1 | Final-round key state is ready |
| round_key_o | output | 64 | Current round key |
| round_o | output | 5 | Current round number |

## Verification
The bench checks hand-computed round keys from the all-zero and all-one keys. A design with the rotation in the wrong direction, a wrong S-box entry or the counter XORed at the wrong bits would miss these values. The bench also walks 31 steps forward and 31 back. A backward step that uses the counter before decrementing it, instead of after, breaks that round trip and does not give back the loaded key.

The fast-forward run is sampled at step 30 and step 31. A done flag that is one cycle early or late shows up there. So does a run that lets step pulses, direction changes or a second start during the run alter the result. Load during a run and load together with step are also driven: a design that gets the priority wrong would leave a stepped key in place or raise a stale done flag.

// File: rtl/rks_pkg.sv
package rks_pkg;

  localparam int NIB_W = 4;

  function automatic logic [NIB_W-1:0] sub_fwd(input logic [NIB_W-1:0] x);
    logic [NIB_W-1:0] y;
    case (x)
      4'h0: y = 4'hC;  4'h1: y = 4'h5;  4'h2: y = 4'h6;  4'h3: y = 4'hB;
      4'h4: y = 4'h9;  4'h5: y = 4'h0;  4'h6: y = 4'hA;  4'h7: y = 4'hD;
      4'h8: y = 4'h3;  4'h9: y = 4'hE;  4'hA: y = 4'hF;  4'hB: y = 4'h8;
      4'hC: y = 4'h4;  4'hD: y = 4'h7;  4'hE: y = 4'h1;  default: y = 4'h2;
    endcase
    return y;
  endfunction

  function automatic logic [NIB_W-1:0] sub_inv(input logic [NIB_W-1:0] x);
    logic [NIB_W-1:0] y;
    case (x)
      4'h0: y = 4'h5;  4'h1: y = 4'hE;  4'h2: y = 4'hF;  4'h3: y = 4'h8;
      4'h4: y = 4'hC;  4'h5: y = 4'h1;  4'h6: y = 4'h2;  4'h7: y = 4'hD;
      4'h8: y = 4'hB;  4'h9: y = 4'h4;  4'hA: y = 4'h6;  4'hB: y = 4'h3;
      4'hC: y = 4'h0;  4'hD: y = 4'h7;  4'hE: y = 4'h9;  default: y = 4'hA;
    endcase
    return y;
  endfunction

endpackage

// File: rtl/rks_fwd_round.sv
module rks_fwd_round #(
  parameter int KEY_W   = 80,
  parameter int CTR_W   = 5,
  parameter int ROT     = 61,
  parameter int CTR_LSB = 15
) (
  input  logic [KEY_W-1:0] key_i,
  input  logic [CTR_W-1:0] ctr_i,
  output logic [KEY_W-1:0] key_o
);
  import rks_pkg::*;

  logic [KEY_W-1:0] rotated;

  always_comb begin
    rotated = (key_i << ROT) | (key_i >> (KEY_W - ROT));
    key_o = rotated;
    key_o[KEY_W-1 -: NIB_W] = sub_fwd(rotated[KEY_W-1 -: NIB_W]);
    key_o[CTR_LSB +: CTR_W] = rotated[CTR_LSB +: CTR_W] ^ ctr_i;
  end

endmodule

// File: rtl/rks_bwd_round.sv
module rks_bwd_round #(
  parameter int KEY_W   = 80,
  parameter int CTR_W   = 5,
  parameter int ROT     = 61,
  parameter int CTR_LSB = 15
) (
  input  logic [KEY_W-1:0] key_i,
  input  logic [CTR_W-1:0] ctr_i,
  output logic [KEY_W-1:0] key_o
);
  import rks_pkg::*;

  logic [KEY_W-1:0] unmixed;

  always_comb begin
    unmixed = key_i;
    unmixed[CTR_LSB +: CTR_W] = key_i[CTR_LSB +: CTR_W] ^ ctr_i;
    unmixed[KEY_W-1 -: NIB_W] = sub_inv(key_i[KEY_W-1 -: NIB_W]);
    key_o = (unmixed >> ROT) | (unmixed << (KEY_W - ROT));
  end

endmodule

// File: rtl/rks_ffwd_seq.sv
module rks_ffwd_seq #(
  parameter int ROUNDS = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic start_i,
  input  logic manual_i,
  output logic run_o,
  output logic busy_o,
  output logic done_o
);
  localparam int LW = $clog2(ROUNDS + 1);

  logic [LW-1:0] left_q;
  logic          done_q;
  logic          accept;

  assign busy_o = (left_q != '0);
  assign accept = start_i && !load_i && !busy_o;
  assign run_o  = !load_i && (accept || busy_o);
  assign done_o = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      done_q <= 1'b0;
    end else if (load_i) begin
      left_q <= '0;
      done_q <= 1'b0;
    end else if (accept) begin
      left_q <= LW'(ROUNDS - 1);
      done_q <= (ROUNDS == 1);
    end else if (busy_o) begin
      left_q <= left_q - LW'(1);
      done_q <= (left_q == LW'(1));
    end else if (manual_i) begin
      done_q <= 1'b0;
    end
  end

  // checker: length of each busy stretch
  logic [LW:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len <= '0;
    else if (busy_o) run_len <= run_len + (LW+1)'(1);
    else             run_len <= '0;
  end

  assert_run_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= (LW+1)'(ROUNDS));

  assert_done_after_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(run_o));

  assert_load_clears_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !done_o && !busy_o);

endmodule

// File: rtl/rkey_sched80.sv
module rkey_sched80 #(
  parameter int KEY_W   = 80,
  parameter int RK_W    = 64,
  parameter int CTR_W   = 5,
  parameter int ROUNDS  = 31,
  parameter int ROT     = 61,
  parameter int CTR_LSB = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             step_i,
  input  logic             dir_i,
  input  logic             ff_start_i,
  output logic             ff_done_o,
  output logic [RK_W-1:0]  round_key_o,
  output logic [CTR_W-1:0] round_o
);
  localparam int RK_LSB = KEY_W - RK_W;

  logic [KEY_W-1:0] key_q, key_fwd, key_bwd;
  logic [CTR_W-1:0] ctr_q, ctr_prev;
  logic             run, busy, manual;

  assign ctr_prev = ctr_q - CTR_W'(1);
  assign manual   = step_i && !load_i;

  rks_fwd_round #(.KEY_W(KEY_W), .CTR_W(CTR_W), .ROT(ROT), .CTR_LSB(CTR_LSB)) u_fwd (
    .key_i(key_q), .ctr_i(ctr_q), .key_o(key_fwd));

  rks_bwd_round #(.KEY_W(KEY_W), .CTR_W(CTR_W), .ROT(ROT), .CTR_LSB(CTR_LSB)) u_bwd (
    .key_i(key_q), .ctr_i(ctr_prev), .key_o(key_bwd));

  rks_ffwd_seq #(.ROUNDS(ROUNDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(ff_start_i),
    .manual_i(manual), .run_o(run), .busy_o(busy), .done_o(ff_done_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      ctr_q <= CTR_W'(1);
    end else if (load_i) begin
      key_q <= key_i;
      ctr_q <= CTR_W'(1);
    end else if (run || (step_i && !dir_i)) begin
      key_q <= key_fwd;
      ctr_q <= ctr_q + CTR_W'(1);
    end else if (step_i) begin
      key_q <= key_bwd;
      ctr_q <= ctr_prev;
    end
  end

  assign round_key_o = key_q[KEY_W-1:RK_LSB];
  assign round_o     = ctr_q;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (round_o == CTR_W'(1)) && (key_q == $past(key_i)) && !ff_done_o);

  assert_fwd_round_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !dir_i && !load_i) |=> round_o == $past(round_o) + CTR_W'(1));

  assert_fwd_rotate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !dir_i && !load_i) |=> key_q[60:20] == $past(key_q[79:39]));

  assert_bwd_round_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && dir_i && !load_i && !ff_start_i && !busy) |=>
      round_o == $past(round_o) - CTR_W'(1));

  assert_busy_ignores_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step_i && dir_i && !load_i) |=> round_o == $past(round_o) + CTR_W'(1));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i && !ff_start_i && !busy) |=> $stable(key_q) && $stable(round_o));

endmodule

// File: tb/test_rkey_sched80.sv
`timescale 1ns/1ps
module test_rkey_sched80;
  localparam real HALF = 2.5;

  logic        clk = 0, rst_n = 0;
  logic        load_i = 0, step_i = 0, dir_i = 0, ff_start_i = 0;
  logic [79:0] key_i = '0;
  logic        ff_done_o;
  logic [63:0] round_key_o;
  logic [4:0]  round_o;

  int n_run = 0, n_fail = 0;

  always #(HALF) clk = ~clk;

  rkey_sched80 i_rkey_sched80 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .key_i(key_i), .step_i(step_i),
    .dir_i(dir_i), .ff_start_i(ff_start_i), .ff_done_o(ff_done_o),
    .round_key_o(round_key_o), .round_o(round_o));

  localparam logic [3:0] SB  [16] = '{4'hC,4'h5,4'h6,4'hB,4'h9,4'h0,4'hA,4'hD,
                                      4'h3,4'hE,4'hF,4'h8,4'h4,4'h7,4'h1,4'h2};
  localparam logic [3:0] ISB [16] = '{4'h5,4'hE,4'hF,4'h8,4'hC,4'h1,4'h2,4'hD,
                                      4'hB,4'h4,4'h6,4'h3,4'h0,4'h7,4'h9,4'hA};

  function automatic logic [79:0] m_fwd(input logic [79:0] k, input logic [4:0] c);
    logic [79:0] t;
    t = {k[18:0], k[79:19]};
    t[79:76] = SB[t[79:76]];
    t[19:15] = t[19:15] ^ c;
    return t;
  endfunction

  function automatic logic [79:0] m_bwd(input logic [79:0] k, input logic [4:0] c);
    logic [79:0] t;
    t = k;
    t[19:15] = t[19:15] ^ c;
    t[79:76] = ISB[t[79:76]];
    return {t[60:0], t[79:61]};
  endfunction

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_load(input logic [79:0] k);
    key_i = k; load_i = 1; @(negedge clk); load_i = 0;
  endtask

  task automatic do_steps(input int n, input logic d);
    for (int i = 0; i < n; i++) begin
      step_i = 1; dir_i = d; @(negedge clk);
    end
    step_i = 0; dir_i = 0;
  endtask

  typedef struct packed {
    logic [79:0] key;
    logic [5:0]  nf;
    logic [5:0]  nb;
    logic        use_model;
    logic [63:0] rk;
    logic [4:0]  rnd;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{80'h0, 6'd1, 6'd0, 1'b0, 64'hC000_0000_0000_0000, 5'd2},
    '{{80{1'b1}}, 6'd1, 6'd0, 1'b0, 64'h2FFF_FFFF_FFFF_FFFF, 5'd2},
    '{80'h0, 6'd2, 6'd0, 1'b0, 64'h5000_1800_0000_0001, 5'd3},
    '{80'h0123_4567_89AB_CDEF_FEDC, 6'd31, 6'd31, 1'b0, 64'h0123_4567_89AB_CDEF, 5'd1},
    '{80'hA5A5_0F0F_3C3C_9696_1234, 6'd5, 6'd5, 1'b0, 64'hA5A5_0F0F_3C3C_9696, 5'd1},
    '{80'hFFFF_0000_FFFF_0000_FFFF, 6'd31, 6'd0, 1'b1, 64'h0, 5'd0},
    '{80'h1357_9BDF_0246_8ACE_55AA, 6'd0, 6'd1, 1'b1, 64'h0, 5'd0}
  };

  initial begin : watchdog
    #(HALF * 2 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [79:0] mk, xk;
    logic [4:0]  mc;

    // R1: during and after reset
    idle(2);
    chk("R1 rk in reset", {16'h0, round_key_o}, 80'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 round", {75'h0, round_o}, 80'd1);
    chk("R1 done", {79'h0, ff_done_o}, 80'd0);

    // vector table: R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      do_load(VEC[v].key);
      do_steps(int'(VEC[v].nf), 1'b0);
      do_steps(int'(VEC[v].nb), 1'b1);
      if (VEC[v].use_model) begin
        mk = VEC[v].key; mc = 5'd1;
        for (int i = 0; i < int'(VEC[v].nf); i++) begin mk = m_fwd(mk, mc); mc = mc + 5'd1; end
        for (int i = 0; i < int'(VEC[v].nb); i++) begin mc = mc - 5'd1; mk = m_bwd(mk, mc); end
        chk("R4 R6 R3 model round key", {16'h0, round_key_o}, {16'h0, mk[79:16]});
        chk("R5 R6 round", {75'h0, round_o}, {75'h0, mc});
      end else begin
        chk("R4 R7 R3 round key", {16'h0, round_key_o}, {16'h0, VEC[v].rk});
        chk("R5 R7 round", {75'h0, round_o}, {75'h0, VEC[v].rnd});
      end
    end

    // R8: hold when idle
    do_load(80'hDEAD_BEEF_0000_1111_2222);
    do_steps(3, 1'b0);
    mk = {round_key_o, 16'h0}; mc = round_o;
    idle(4);
    chk("R8 hold key", {16'h0, round_key_o}, {16'h0, mk[79:16]});
    chk("R8 hold round", {75'h0, round_o}, {75'h0, mc});

    // R2: load beats step and ff_start
    key_i = 80'h0F0F_F0F0_1234_5678_9ABC;
    load_i = 1; step_i = 1; ff_start_i = 1;
    @(negedge clk);
    load_i = 0; step_i = 0; ff_start_i = 0;
    idle(2);
    chk("R2 priority key", {16'h0, round_key_o}, {16'h0, 64'h0F0F_F0F0_1234_5678});
    chk("R2 round", {75'h0, round_o}, 80'd1);
    chk("R2 done", {79'h0, ff_done_o}, 80'd0);

    // R9 R10: fast-forward with disturbance
    xk = 80'h0123_4567_89AB_CDEF_FEDC;
    do_load(xk);
    mk = xk; mc = 5'd1;
    for (int i = 0; i < 31; i++) begin mk = m_fwd(mk, mc); mc = mc + 5'd1; end
    ff_start_i = 1; @(negedge clk); ff_start_i = 0;
    idle(9);
    step_i = 1; dir_i = 1; ff_start_i = 1; @(negedge clk);
    step_i = 0; dir_i = 0; ff_start_i = 0;
    idle(19);
    chk("R9 done not early", {79'h0, ff_done_o}, 80'd0);
    @(negedge clk);
    chk("R9 done at 31", {79'h0, ff_done_o}, 80'd1);
    chk("R9 R10 final key", {16'h0, round_key_o}, {16'h0, mk[79:16]});
    chk("R5 wrap round", {75'h0, round_o}, 80'd0);
    idle(3);
    chk("R10 done held", {79'h0, ff_done_o}, 80'd1);
    do_steps(31, 1'b1);
    chk("R10 done cleared by step", {79'h0, ff_done_o}, 80'd0);
    chk("R7 R6 back to key", {16'h0, round_key_o}, {16'h0, xk[79:16]});
    chk("R7 round", {75'h0, round_o}, 80'd1);

    // R11: load aborts a run
    ff_start_i = 1; @(negedge clk); ff_start_i = 0;
    idle(5);
    do_load(80'h5555_AAAA_3333_CCCC_7777);
    idle(35);
    chk("R11 done low", {79'h0, ff_done_o}, 80'd0);
    chk("R11 key kept", {16'h0, round_key_o}, {16'h0, 64'h5555_AAAA_3333_CCCC});
    chk("R11 round", {75'h0, round_o}, 80'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule